// File: doc/BRIEF.md
# Alert-Response Address Responder

This block is the part of an I2C target that lets an interrupting sensor identify itself when the bus controller broadcasts the SMBus Alert Response Address (ARA). It takes in the bus SCL and SDA lines and synchronises them. It drives SDA only through an open-drain pull-down enable. It also owns the active-low interrupt output of the sensor. The interrupt logic works in one of two modes. In latched mode, a rising alert request holds the interrupt until an alert response clears it. In transparent mode, the interrupt follows the request level and the block never answers the ARA.

During an alert-response read, the controller sends the ARA with the read bit set. The block acknowledges, then shifts out its 7-bit address, MSB first, with the high-threshold flag added as the final bit. Several targets may answer at once on the wired-AND line. Each target compares every bit it releases against the bus, and stops driving at the first mismatch, so the numerically lowest address wins. Only the winner releases its interrupt. A loser stays asserted, and the controller repeats the alert response until every interrupt line has cleared. The flag input is only reported and never modified.

There is no data stream at this block's edge. Every pin is a plain control or status level, so there is no valid/ready handshake and no back-pressure.

Top module: `ara_responder`

## Requirements
- R1: In latched mode, with the interrupt asserted, an address byte equal to 0x19 (address 7'b0001100, read bit 1) is acknowledged: SDA is pulled low during the ninth SCL clock.
- R2: In transparent mode (`latched_mode`=0) the ARA is never acknowledged, and `irq_n` is the inverse of the `alert_req` level.
- R3: Any address byte other than 0x19, including the ARA with the write bit (0x18), gets no acknowledge and leaves the interrupt unchanged.
- R4: After the acknowledge, the returned byte is {`dev_addr_hi`[4:0], `addr_strap`[1:0], `flag_hi`}, sent MSB first. The flag occupies byte bit 0.
- R5: A bit sent as 1 that is read back as 0 on a rising SCL is a lost arbitration. The block releases SDA for the rest of that transaction, so the lowest address wins.
- R6: After a lost arbitration, `irq_n` stays low.
- R7: A target that sends all eight data bits without a loss drives `irq_n` high.
- R8: In latched mode, a rising edge on `alert_req` drives `irq_n` low, and it stays low after the request falls, until an R7 win.
- R9: A START or STOP at any point abandons the transaction in progress. A STOP in mid-byte leaves the interrupt asserted, and a following complete alert response is answered.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| latched_mode | input | 1 | 1 latched window mode, 0 transparent mode |
| alert_req | input | 1 | Alert condition from the threshold logic |
| flag_hi | input | 1 | High-threshold flag returned as the last address bit |
| dev_addr_hi | input | 5 | Fixed upper address bits |
| addr_strap | input | 2 | Strap-selected lower address bits |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bound checker watches several rules on every cycle. SDA may only move while SCL is low. A target that has lost stays silent and keeps its interrupt asserted. A win releases the interrupt. In latched mode the interrupt may rise only after a win, and the block drives SDA only in latched mode. Other behaviour needs complete bus transactions, so only the bench scenarios can show it. The bench checks the exact returned byte and the acknowledge decision for each address. It also runs a two-target contest on a shared wired-AND line, where the lower address wins and the repeated response reaches the other target. A STOP in mid-byte must abandon the transaction and still leave the alert served by the next response.

// File: rtl/ara_pkg.sv
package ara_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned I2C_AW   = 7;
  localparam logic [I2C_AW-1:0] ARA_ADDR = 7'b0001100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_WAIT,
    ST_ACK,
    ST_SEND,
    ST_RELEASE,
    ST_PARK
  } ara_state_e;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
    logic sda;
  } bus_evt_t;
endpackage

// File: rtl/ara_bus_sense.sv
module ara_bus_sense
  import ara_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt
);
  logic scl_s, sda_s, scl_d, sda_d;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
          sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
        end
      end
      assign scl_s = scl_sh[SYNC_STAGES-1];
      assign sda_s = sda_sh[SYNC_STAGES-1];
    end else begin : g_single
      logic scl_r, sda_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_r <= 1'b1;
          sda_r <= 1'b1;
        end else begin
          scl_r <= scl_i;
          sda_r <= sda_i;
        end
      end
      assign scl_s = scl_r;
      assign sda_s = sda_r;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  always_comb begin
    evt.scl_rise = scl_s & ~scl_d;
    evt.scl_fall = ~scl_s & scl_d;
    evt.start    = scl_s & scl_d & sda_d & ~sda_s;
    evt.stop     = scl_s & scl_d & ~sda_d & sda_s;
    evt.sda      = sda_s;
  end
endmodule

// File: rtl/ara_proto_fsm.sv
module ara_proto_fsm
  import ara_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt,
  input  logic              answer_en,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_drive,
  output logic              win,
  output logic              lost
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);
  localparam logic [BYTE_W-1:0] ARA_RD = {ARA_ADDR, 1'b1};

  ara_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-2:0] rx_q;
  logic [BYTE_W-1:0] tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      sda_drive <= 1'b0;
      win       <= 1'b0;
      lost      <= 1'b0;
    end else begin
      win <= 1'b0;
      if (evt.stop) begin
        state     <= ST_IDLE;
        sda_drive <= 1'b0;
        lost      <= 1'b0;
      end else if (evt.start) begin
        state     <= ST_ADDR;
        cnt       <= '0;
        sda_drive <= 1'b0;
        lost      <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: if (evt.scl_rise) begin
            rx_q <= {rx_q[BYTE_W-3:0], evt.sda};
            cnt  <= cnt + 1'b1;
            if (cnt == LAST)
              state <= (({rx_q, evt.sda} == ARA_RD) && answer_en) ? ST_ACK_WAIT : ST_PARK;
          end
          ST_ACK_WAIT: if (evt.scl_fall) begin
            sda_drive <= 1'b1;
            state     <= ST_ACK;
          end
          ST_ACK: if (evt.scl_fall) begin
            tx_q      <= tx_byte;
            sda_drive <= ~tx_byte[BYTE_W-1];
            cnt       <= '0;
            state     <= ST_SEND;
          end
          ST_SEND: begin
            if (evt.scl_rise) begin
              if (!sda_drive && !evt.sda) begin
                lost  <= 1'b1;
                state <= ST_PARK;
              end else if (cnt == LAST) begin
                win   <= 1'b1;
                state <= ST_RELEASE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end else if (evt.scl_fall) begin
              sda_drive <= ~tx_q[BYTE_W-2];
              tx_q      <= {tx_q[BYTE_W-2:0], 1'b0};
            end
          end
          ST_RELEASE: if (evt.scl_fall) begin
            sda_drive <= 1'b0;
            state     <= ST_PARK;
          end
          ST_PARK:  sda_drive <= 1'b0;
          default:  sda_drive <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ara_irq_ctl.sv
module ara_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic alert_req,
  input  logic latched_mode,
  input  logic win,
  output logic pending,
  output logic irq_active
);
  logic alert_q;
  logic alert_rise;

  assign alert_rise = alert_req & ~alert_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alert_q <= 1'b0;
      pending <= 1'b0;
    end else begin
      alert_q <= alert_req;
      pending <= latched_mode & (alert_rise | (pending & ~win));
    end
  end

  assign irq_active = latched_mode ? pending : alert_q;
endmodule

// File: rtl/ara_responder.sv
module ara_responder
  import ara_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STRAP_W     = 2,
  localparam int unsigned HI_W       = I2C_AW - STRAP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  input  logic            latched_mode,
  input  logic            alert_req,
  input  logic            flag_hi,
  input  logic [HI_W-1:0] dev_addr_hi,
  input  logic [STRAP_W-1:0] addr_strap,
  output logic            irq_n
);
  bus_evt_t          evt;
  logic              pending, irq_active;
  logic              win, lost, drive;
  logic [BYTE_W-1:0] tx_byte;

  assign tx_byte = {dev_addr_hi, addr_strap, flag_hi};

  ara_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt   (evt)
  );

  ara_proto_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .answer_en (latched_mode & pending),
    .tx_byte   (tx_byte),
    .sda_drive (drive),
    .win       (win),
    .lost      (lost)
  );

  ara_irq_ctl u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .alert_req    (alert_req),
    .latched_mode (latched_mode),
    .win          (win),
    .pending      (pending),
    .irq_active   (irq_active)
  );

  assign sda_oe = drive;
  assign irq_n  = ~irq_active;
endmodule

// File: rtl/ara_checker.sv
module ara_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic irq_n,
  input logic latched_mode,
  input logic alert_req,
  input logic win,
  input logic lost
);
  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  a_r2_no_drive_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> latched_mode);

  a_r5_silent_after_loss: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> !sda_oe);

  a_r6_loss_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> !irq_n);

  a_r7_win_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (win && !alert_req && latched_mode) |=> irq_n);

  a_r8_irq_rises_on_win: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_mode && $past(latched_mode) && $rose(irq_n)) |-> $past(win));
endmodule

bind ara_responder ara_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_i        (scl_i),
  .sda_oe       (sda_oe),
  .irq_n        (irq_n),
  .latched_mode (latched_mode),
  .alert_req    (alert_req),
  .win          (win),
  .lost         (lost)
);

// File: tb/sim_ara_responder.sv
`timescale 1ns/1ps
module sim_ara_responder;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic mode = 1'b0;
  logic al0 = 1'b0, al1 = 1'b0;
  logic fl0 = 1'b0, fl1 = 1'b0;
  logic oe0, oe1, irq0, irq1;
  logic bus_sda;
  int checks = 0, failures = 0, r10_viol = 0;
  logic oe0_hi = 1'b0, oe0_last = 1'b0;
  logic oe0_prev = 1'b0, oe1_prev = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign bus_sda = m_sda & ~oe0 & ~oe1;

  ara_responder u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda), .sda_oe(oe0),
    .latched_mode(mode), .alert_req(al0), .flag_hi(fl0),
    .dev_addr_hi(5'b10010), .addr_strap(2'b11), .irq_n(irq0));

  ara_responder u1 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda), .sda_oe(oe1),
    .latched_mode(mode), .alert_req(al1), .flag_hi(fl1),
    .dev_addr_hi(5'b10010), .addr_strap(2'b01), .irq_n(irq1));

  always @(posedge clk) begin
    if (rst_n && m_scl && (oe0 != oe0_prev || oe1 != oe1_prev)) r10_viol++;
    oe0_prev = oe0;
    oe1_prev = oe1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b, output logic rd);
    m_sda = b; wq(); m_scl = 1'b1; wq();
    rd = bus_sda; oe0_hi = oe0;
    wq(); m_scl = 1'b0; wq();
  endtask

  task automatic xfer(input logic [7:0] ab, input int nbits, output logic acked,
                      output logic [7:0] rd);
    logic b;
    bus_start();
    for (int i = 7; i >= 0; i--) put_bit(ab[i], b);
    put_bit(1'b1, b);
    acked = ~b;
    rd = '0;
    if (acked) begin
      for (int i = 0; i < nbits; i++) begin
        put_bit(1'b1, b);
        rd = {rd[6:0], b};
        if (i == 7) oe0_last = oe0_hi;
      end
      if (nbits == 8) put_bit(1'b1, b);
    end
    bus_stop();
  endtask

  task automatic pulse0(); al0 = 1'b1; repeat (3) @(negedge clk); al0 = 1'b0; repeat (3) @(negedge clk); endtask
  task automatic pulse1(); al1 = 1'b1; repeat (3) @(negedge clk); al1 = 1'b0; repeat (3) @(negedge clk); endtask

  task automatic t_reset();
    chk("R8 reset irq0", irq0, 1);
    chk("R8 reset irq1", irq1, 1);
    chk("R10 reset oe", {oe0, oe1}, 0);
  endtask

  task automatic t_transparent();
    logic a; logic [7:0] d;
    mode = 1'b0; al0 = 1'b1; repeat (4) @(negedge clk);
    chk("R2 irq follows level", irq0, 0);
    xfer(8'h19, 8, a, d);
    chk("R2 no ack transparent", a, 0);
    al0 = 1'b0; repeat (4) @(negedge clk);
    chk("R2 irq follows low level", irq0, 1);
  endtask

  task automatic t_latch();
    mode = 1'b1; repeat (4) @(negedge clk);
    pulse0();
    chk("R8 irq0 held after pulse", irq0, 0);
    chk("R8 irq1 untouched", irq1, 1);
  endtask

  task automatic t_other_addr();
    logic a; logic [7:0] d;
    xfer(8'h18, 8, a, d);
    chk("R3 write bit no ack", a, 0);
    xfer(8'h1B, 8, a, d);
    chk("R3 other address no ack", a, 0);
    chk("R3 irq0 unchanged", irq0, 0);
  endtask

  task automatic t_single();
    logic a; logic [7:0] d;
    fl0 = 1'b1;
    xfer(8'h19, 8, a, d);
    chk("R1 ack", a, 1);
    chk("R4 byte", d, 8'h97);
    repeat (4) @(negedge clk);
    chk("R7 irq0 released", irq0, 1);
  endtask

  task automatic t_stop_mid();
    logic a; logic [7:0] d;
    pulse0();
    xfer(8'h19, 3, a, d);
    chk("R9 ack before abort", a, 1);
    chk("R9 partial bits", d, 8'h4);
    repeat (4) @(negedge clk);
    chk("R9 oe released after stop", oe0, 0);
    chk("R9 irq0 still low", irq0, 0);
    bus_start();
    for (int i = 7; i >= 4; i--) begin logic b; put_bit(8'h19 >> i, b); end
    xfer(8'h19, 8, a, d);
    chk("R9 answered after restart", a, 1);
    chk("R9 byte after restart", d, 8'h97);
    repeat (4) @(negedge clk);
    chk("R7 irq0 released after restart", irq0, 1);
  endtask

  task automatic t_arb();
    logic a; logic [7:0] d;
    fl0 = 1'b0; fl1 = 1'b1;
    pulse0(); pulse1();
    xfer(8'h19, 8, a, d);
    chk("R5 ack", a, 1);
    chk("R5 lower address wins", d, 8'h93);
    chk("R5 loser silent at last bit", oe0_last, 0);
    repeat (4) @(negedge clk);
    chk("R7 winner irq1 released", irq1, 1);
    chk("R6 loser irq0 held", irq0, 0);
    xfer(8'h19, 8, a, d);
    chk("R4 second response byte", d, 8'h96);
    repeat (4) @(negedge clk);
    chk("R7 irq0 released on repeat", irq0, 1);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_transparent();
    t_latch();
    t_other_addr();
    t_single();
    t_stop_mid();
    t_arb();
    chk("R10 no SDA change with SCL high", r10_viol, 0);
    done = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
    end
  end
endmodule